// File: doc/BRIEF.md
# Latch Output Expander Controller

This block lets a small group of chip pins drive a much larger set of output-only lines by way of a bank of external latches. The latches all share one set of data pins. Each latch has its own clock pin. A client sends single-bit write requests. Each request carries a global line index and the value for that line. The block keeps a shadow copy of every latch and changes only the addressed bit in that copy. It then drives the whole updated latch word onto the shared data pins and pulses the clock pin of that one latch.

The bank has `NUM_LATCH` latches of `LATCH_W` bits, which gives `NUM_LATCH*LATCH_W` lines from `NUM_LATCH+LATCH_W` pins. The defaults of 2 latches of 8 bits give 16 lines from 10 pins. Three parameters set the strobe timing: the setup cycles before the clock rises, the width of the clock pulse, and the hold cycles after it falls. Requests are taken one at a time through a valid/ready handshake.

Top module: `latch_expander`

## Requirements
- R1: While reset is asserted and after it is released, `data_o` and `lclk_o` are all zero, every shadow word is zero and `req_ready_o` is high.
- R2: A request with index k targets latch k / LATCH_W, and within that latch the bit at position k % LATCH_W. Bit 0 of the latch word is `data_o[0]`, and latch j is clocked by `lclk_o[j]`.
- R3: A write changes only the addressed bit of the target shadow word. All other bits and all other latches keep their values.
- R4: From the cycle after acceptance, `data_o` carries the complete updated shadow word of the target latch.
- R5: `data_o` is driven for SETUP_CYC cycles. Then exactly one clock line, the one for the target latch, goes high for PULSE_CYC cycles. No two clock lines are ever high together.
- R6: `req_ready_o` drops in the cycle after an in-range acceptance. It stays low through the setup, the pulse and HOLD_CYC hold cycles, and then returns high. A request held valid meanwhile waits and is taken afterwards.
- R7: `data_o` does not change while any clock line is high, or in the cycle in which a clock line falls.
- R8: A request with index at least NUM_LATCH*LATCH_W is accepted. It leaves `data_o`, the shadow words and `lclk_o` unchanged, and `req_ready_o` stays high.
- R9: `dir_out_o` always reads 1, meaning every expanded line is an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_idx_i | input | IDX_W | Global line index, IDX_W = clog2(NUM_LATCH*LATCH_W)+1 |
| req_val_i | input | 1 | Value for the addressed line |
| data_o | output | LATCH_W | Shared latch data pins |
| lclk_o | output | NUM_LATCH | Per-latch clock pins |
| dir_out_o | output | 1 | Direction status, always output |

## Verification
If a shadow word is corrupted, the fault does not appear at once. It shows up on `data_o` the next time any bit of that latch is written, one cycle after acceptance. The bench therefore writes each latch several times and checks `data_o` on every cycle. A wrong sequencer count shows on `lclk_o` or `req_ready_o` in the exact cycle where it goes wrong, because the reference model knows the expected phase of every cycle. A wrong index split either sends the pulse to the wrong clock line or puts the new bit in the wrong position. Both show up within SETUP_CYC+1 cycles of acceptance.

// File: rtl/lx_pkg.sv
package lx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD} lx_state_e;
endpackage

// File: rtl/lx_index_dec.sv
module lx_index_dec #(
  parameter int NUM_LATCH = 2,
  parameter int LATCH_W   = 8,
  parameter int IDX_W     = 5
) (
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_LATCH-1:0] lat_oh_o,
  output logic [LATCH_W-1:0]   bit_oh_o,
  output logic                 in_range_o
);
  logic [IDX_W-1:0] quot, rem;

  assign quot = idx_i / IDX_W'(LATCH_W);
  assign rem  = idx_i % IDX_W'(LATCH_W);

  for (genvar l = 0; l < NUM_LATCH; l++) begin : g_lat
    assign lat_oh_o[l] = (quot == IDX_W'(l));
  end
  for (genvar b = 0; b < LATCH_W; b++) begin : g_bit
    assign bit_oh_o[b] = (rem == IDX_W'(b));
  end

  // quotient beyond the last latch matches no one-hot slot
  assign in_range_o = |lat_oh_o;
endmodule

// File: rtl/lx_shadow_bank.sv
module lx_shadow_bank #(
  parameter int NUM_LATCH = 2,
  parameter int LATCH_W   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [NUM_LATCH-1:0] lat_oh_i,
  input  logic [LATCH_W-1:0]   bit_oh_i,
  input  logic                 val_i,
  output logic [LATCH_W-1:0]   upd_word_o
);
  logic [NUM_LATCH-1:0][LATCH_W-1:0] sh_q;
  logic [LATCH_W-1:0] cur_word;

  always_comb begin
    cur_word = '0;
    for (int l = 0; l < NUM_LATCH; l++)
      if (lat_oh_i[l]) cur_word = cur_word | sh_q[l];
  end

  assign upd_word_o = (cur_word & ~bit_oh_i) | (val_i ? bit_oh_i : '0);

  for (genvar l = 0; l < NUM_LATCH; l++) begin : g_sh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      sh_q[l] <= '0;
      else if (wr_en_i && lat_oh_i[l])  sh_q[l] <= upd_word_o;
    end
  end
endmodule

// File: rtl/lx_strobe_seq.sv
module lx_strobe_seq
  import lx_pkg::*;
#(
  parameter int NUM_LATCH = 2,
  parameter int LATCH_W   = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [NUM_LATCH-1:0] lat_oh_i,
  input  logic [LATCH_W-1:0]   word_i,
  output logic                 idle_o,
  output logic [LATCH_W-1:0]   data_o,
  output logic [NUM_LATCH-1:0] lclk_o
);
  localparam int MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_C = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  lx_state_e            state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [LATCH_W-1:0]   data_q;
  logic [NUM_LATCH-1:0] sel_q, lclk_q;
  logic                 last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
      sel_q   <= '0;
      lclk_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          data_q  <= word_i;
          sel_q   <= lat_oh_i;
          cnt_q   <= CNT_W'(SETUP_CYC - 1);
          state_q <= ST_SETUP;
        end
        ST_SETUP: if (last) begin
          lclk_q  <= sel_q;   // registered strobe, glitch-free pin
          cnt_q   <= CNT_W'(PULSE_CYC - 1);
          state_q <= ST_PULSE;
        end else cnt_q <= cnt_q - 1'b1;
        ST_PULSE: if (last) begin
          lclk_q  <= '0;
          cnt_q   <= CNT_W'(HOLD_CYC - 1);
          state_q <= ST_HOLD;
        end else cnt_q <= cnt_q - 1'b1;
        ST_HOLD: if (last) state_q <= ST_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign data_o = data_q;
  assign lclk_o = lclk_q;
endmodule

// File: rtl/latch_expander.sv
module latch_expander #(
  parameter int NUM_LATCH = 2,
  parameter int LATCH_W   = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1,
  localparam int IDX_W    = $clog2(NUM_LATCH * LATCH_W) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [IDX_W-1:0]     req_idx_i,
  input  logic                 req_val_i,
  output logic [LATCH_W-1:0]   data_o,
  output logic [NUM_LATCH-1:0] lclk_o,
  output logic                 dir_out_o
);
  logic [NUM_LATCH-1:0] lat_oh;
  logic [LATCH_W-1:0]   bit_oh, upd_word;
  logic                 in_range, idle, start;

  lx_index_dec #(.NUM_LATCH(NUM_LATCH), .LATCH_W(LATCH_W), .IDX_W(IDX_W)) u_dec (
    .idx_i      (req_idx_i),
    .lat_oh_o   (lat_oh),
    .bit_oh_o   (bit_oh),
    .in_range_o (in_range)
  );

  // out-of-range requests handshake but never start a cycle
  assign start = req_valid_i && idle && in_range;

  lx_shadow_bank #(.NUM_LATCH(NUM_LATCH), .LATCH_W(LATCH_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (start),
    .lat_oh_i   (lat_oh),
    .bit_oh_i   (bit_oh),
    .val_i      (req_val_i),
    .upd_word_o (upd_word)
  );

  lx_strobe_seq #(
    .NUM_LATCH(NUM_LATCH), .LATCH_W(LATCH_W),
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .lat_oh_i (lat_oh),
    .word_i   (upd_word),
    .idle_o   (idle),
    .data_o   (data_o),
    .lclk_o   (lclk_o)
  );

  assign req_ready_o = idle;
  assign dir_out_o   = 1'b1;
endmodule

// File: rtl/latch_expander_chk.sv
module latch_expander_chk #(
  parameter int NUM_LATCH = 2,
  parameter int LATCH_W   = 8,
  parameter int IDX_W     = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_ready_o,
  input logic [IDX_W-1:0]     req_idx_i,
  input logic [LATCH_W-1:0]   data_o,
  input logic [NUM_LATCH-1:0] lclk_o
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_LATCH * LATCH_W);

  a_r5_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lclk_o));

  a_r6_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_idx_i < LIMIT) |=> !req_ready_o);

  a_r6_not_ready_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lclk_o) |-> !req_ready_o);

  a_r7_data_stable_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lclk_o) |-> $stable(data_o));

  a_r7_hold_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|lclk_o) |-> ($stable(data_o) && !req_ready_o));

  a_r8_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_idx_i >= LIMIT)
      |=> (req_ready_o && $stable(data_o) && lclk_o == '0));
endmodule

bind latch_expander latch_expander_chk #(
  .NUM_LATCH(NUM_LATCH), .LATCH_W(LATCH_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_idx_i   (req_idx_i),
  .data_o      (data_o),
  .lclk_o      (lclk_o)
);

// File: tb/latch_expander_test.sv
`timescale 1ns/1ps
module latch_expander_test;
  localparam int N  = 2;
  localparam int W  = 8;
  localparam int S  = 2;
  localparam int PW = 2;
  localparam int H  = 1;
  localparam int IW = $clog2(N * W) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [IW-1:0] idx = '0;
  logic val = 1'b0;
  logic ready, dir;
  logic [W-1:0] data;
  logic [N-1:0] lclk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit live = 0;

  always #2.5 clk = ~clk;

  latch_expander #(.NUM_LATCH(N), .LATCH_W(W), .SETUP_CYC(S), .PULSE_CYC(PW),
                   .HOLD_CYC(H)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_idx_i(idx), .req_val_i(val), .data_o(data), .lclk_o(lclk),
    .dir_out_o(dir));

  // behavioural reference: elapsed-cycle counter per transaction
  logic [W-1:0] m_sh [N];
  logic [W-1:0] m_data;
  int m_el, m_sel, m_l, m_b;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_sh[i] = '0;
      m_data = '0; m_el = 0; m_sel = 0;
    end else if (m_el == 0) begin
      if (valid && int'(idx) < N * W) begin
        m_l = int'(idx) / W;
        m_b = int'(idx) % W;
        m_sh[m_l][m_b] = val;
        m_data = m_sh[m_l];
        m_sel = m_l;
        m_el = 1;
      end
    end else begin
      m_el++;
      if (m_el > S + PW + H) m_el = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && live) begin
      logic [N-1:0] e_clk;
      e_clk = (m_el >= S + 1 && m_el <= S + PW) ? N'(1 << m_sel) : '0;
      chk(data == m_data, "R3 R4 R7 data", int'(data), int'(m_data));
      chk(lclk == e_clk, "R5 clock", int'(lclk), int'(e_clk));
      chk(ready == (m_el == 0), "R6 ready", int'(ready), int'(m_el == 0));
      chk(dir == 1'b1, "R9 direction", int'(dir), 1);
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      summary();
    end
  end

  // called at a negedge; returns at the negedge after acceptance, valid left high
  task automatic send(input int k, input bit v);
    bit acc;
    idx = IW'(k); val = v; valid = 1'b1;
    do begin
      acc = ready;
      @(negedge clk);
    end while (!acc);
  endtask

  task automatic idle(input int n);
    valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(data == '0 && lclk == '0, "R1 reset outputs", int'({data, lclk}), 0);
    chk(ready == 1'b1, "R1 reset ready", int'(ready), 1);
    rst_n = 1'b1;
    live = 1;
    @(negedge clk);
    chk(data == '0 && lclk == '0 && ready, "R1 after release", int'(data), 0);

    send(3, 1'b1);
    send(11, 1'b1);                       // held valid: waits for R6
    chk(data == 8'h08, "R2 latch1 bit3", int'(data), 8'h08);
    idle(S);
    chk(lclk == 2'b10, "R2 R5 latch1 clock", int'(lclk), 2);
    idle(PW + H + 2);
    send(0, 1'b1);
    send(7, 1'b1);
    chk(data == 8'h89, "R3 latch0 word", int'(data), 8'h89);
    send(3, 1'b0);
    chk(data == 8'h81, "R3 clear bit", int'(data), 8'h81);
    send(20, 1'b1);
    chk(ready == 1'b1 && lclk == '0, "R8 ready kept", int'(ready), 1);
    chk(data == 8'h81, "R8 data kept", int'(data), 8'h81);
    send(31, 1'b0);
    send(15, 1'b1);
    chk(data == 8'h88, "R3 latch1 kept", int'(data), 8'h88);
    send(9, 1'b1);
    send(3, 1'b1);
    chk(data == 8'h89, "R3 latch0 rewrite", int'(data), 8'h89);
    send(3, 1'b1);                        // same value again
    chk(data == 8'h89, "R4 same value", int'(data), 8'h89);
    idle(8);
    send(8, 1'b0);
    chk(data == 8'h8a, "R2 R3 latch1 word", int'(data), 8'h8a);
    idle(4);

    for (int i = 0; i < 60; i++) begin
      send(int'($urandom_range(0, 23)), 1'($urandom_range(0, 1)));
      if ((i % 5) == 0) idle(int'($urandom_range(0, 6)));
    end
    idle(10);
    summary();
  end
endmodule